// File: doc/BRIEF.md
# Iterative Carry-less Multiplier with Operand Half Select

This block forms the product of two 64-bit polynomials with coefficients in GF(2). Partial products are combined by XOR, so no carry ever moves between bit positions, and the result is 128 bits wide. The two factors come from two 128-bit operands. Bit 0 of an 8-bit immediate picks the half of the first operand that is used. Bit 4 picks the half of the second operand.

The unit is iterative. A start request is accepted when the unit is not running, and the selected halves are latched at that point. After that the unit spends one cycle on each multiplier bit, 64 cycles in all, and each cycle it XORs the shifted multiplicand into an accumulator. A one-cycle done pulse marks the end of the run. The product stays on the output until the next start is accepted. Reduction modulo a field polynomial belongs to a later stage and is not part of this block.

The controller has three states: ST_IDLE, ST_RUN and ST_DONE.
- ST_IDLE to ST_RUN happens on an accepted start.
- ST_RUN to ST_RUN happens while the step counter is below its last value.
- ST_RUN to ST_DONE happens on the last step.
- ST_DONE to ST_RUN happens when a start arrives during the pulse cycle.
- ST_DONE to ST_IDLE happens otherwise.

Top module: `clmul_unit`

## Requirements
- R1: `prod_o` equals the carry-less product of the two selected 64-bit factors: the XOR over every set bit i of the second factor of the first factor shifted left by i. The product is 128 bits wide.
- R2: With `imm_i` = 0x00, the factors are `opnd_a_i[63:0]` and `opnd_b_i[63:0]`.
- R3: `imm_i` bit 0 = 1 selects `opnd_a_i[127:64]` as the first factor, so 0x01 multiplies the high half of the first operand by the low half of the second.
- R4: `imm_i` bit 4 = 1 selects `opnd_b_i[127:64]` as the second factor. So 0x10 multiplies the low half of A by the high half of B, and 0x11 multiplies the two high halves.
- R5: Bits 1, 2, 3, 5, 6 and 7 of `imm_i` have no effect on the product.
- R6: A start sampled at rising edge E0 while `busy_o` is low sets `busy_o` high after E0. `done_o` is high in the cycle after edge E64, and `busy_o` is low by then.
- R7: `done_o` is high for exactly one cycle per operation.
- R8: `prod_o` does not change from the done pulse until the next accepted start.
- R9: A start asserted while `busy_o` is high is ignored. The running operation keeps its operands, its latency and its result.
- R10: Bit 127 of `prod_o` is always zero.
- R11: After reset, `busy_o`, `done_o` and `prod_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin an operation |
| opnd_a_i | input | 128 | First operand; one half becomes the first factor |
| opnd_b_i | input | 128 | Second operand; one half becomes the second factor |
| imm_i | input | 8 | Half select: bit 0 picks the half of A, bit 4 picks the half of B |
| busy_o | output | 1 | High while the operation is running |
| done_o | output | 1 | One-cycle pulse when the product is complete |
| prod_o | output | 128 | Carry-less product, held after completion |

## Verification
Each operation uses operands whose four halves are all different random values, so a wrong half selection gives a wrong product. The four selection codes are tried both plain and with every ignored immediate bit set. Directed factors target specific failures:
- all-ones factors fill the product up to bit 126, which catches a carry leak or a shift error at the top;
- a single bit 63 in each factor checks the top bit position;
- zero factors and factors equal to one check the trivial cases.

A start raised in the middle of a run, with different operands, shows whether the block wrongly accepts a start while busy.

// File: rtl/clmul_pkg.sv
package clmul_pkg;

    localparam int unsigned FACTOR_W = 64;
    localparam int unsigned OPND_W   = 2 * FACTOR_W;
    localparam int unsigned PROD_W   = 2 * FACTOR_W;
    localparam int unsigned IMM_W    = 8;
    localparam int unsigned SEL_A_BIT = 0;
    localparam int unsigned SEL_B_BIT = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } clmul_state_e;

endpackage

// File: rtl/clmul_half_select.sv
module clmul_half_select #(
    parameter int unsigned FW = 64
) (
    input  logic [2*FW-1:0] opnd_i,
    input  logic            pick_hi_i,
    output logic [FW-1:0]   factor_o
);

    always_comb begin
        if (pick_hi_i) factor_o = opnd_i[2*FW-1:FW];
        else           factor_o = opnd_i[FW-1:0];
    end

endmodule

// File: rtl/clmul_ctrl.sv
module clmul_ctrl
    import clmul_pkg::*;
#(
    parameter int unsigned STEPS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);

    localparam int unsigned CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

    clmul_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;
            ST_RUN:  if (cnt_q == LAST) state_d = ST_DONE;
            ST_DONE: state_d = start_i ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load_o)        cnt_q <= '0;
        else if (step_o)        cnt_q <= cnt_q + 1'b1;
    end

    // outputs
    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: load_o = start_i;
            ST_RUN: begin
                step_o = 1'b1;
                busy_o = 1'b1;
            end
            ST_DONE: begin
                done_o = 1'b1;
                load_o = start_i;
            end
            default: ;
        endcase
    end

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R9
    run_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cnt_q != LAST) |=> (busy_o && cnt_q == $past(cnt_q) + 1'b1));

    // R6
    run_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cnt_q == LAST) |=> done_o);

endmodule

// File: rtl/clmul_datapath.sv
module clmul_datapath #(
    parameter int unsigned FW = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            step_i,
    input  logic [FW-1:0]   fa_i,
    input  logic [FW-1:0]   fb_i,
    output logic [2*FW-1:0] acc_o
);

    localparam int unsigned PW = 2 * FW;

    logic [PW-1:0] mcand_q;
    logic [FW-1:0] mplier_q;
    logic [PW-1:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            acc_q    <= '0;
        end else if (load_i) begin
            mcand_q  <= {{FW{1'b0}}, fa_i};
            mplier_q <= fb_i;
            acc_q    <= '0;
        end else if (step_i) begin
            if (mplier_q[0]) acc_q <= acc_q ^ mcand_q;
            mcand_q  <= mcand_q << 1;
            mplier_q <= mplier_q >> 1;
        end
    end

    assign acc_o = acc_q;

    // R10
    top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_q[PW-1]);

endmodule

// File: rtl/clmul_unit.sv
module clmul_unit
    import clmul_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [OPND_W-1:0] opnd_a_i,
    input  logic [OPND_W-1:0] opnd_b_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [PROD_W-1:0] prod_o
);

    logic [FACTOR_W-1:0] fa, fb;
    logic load, step;

    clmul_half_select #(.FW(FACTOR_W)) u_sel_a (
        .opnd_i   (opnd_a_i),
        .pick_hi_i(imm_i[SEL_A_BIT]),
        .factor_o (fa)
    );

    clmul_half_select #(.FW(FACTOR_W)) u_sel_b (
        .opnd_i   (opnd_b_i),
        .pick_hi_i(imm_i[SEL_B_BIT]),
        .factor_o (fb)
    );

    clmul_ctrl #(.STEPS(FACTOR_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .load_o (load),
        .step_o (step),
        .busy_o (busy_o),
        .done_o (done_o)
    );

    clmul_datapath #(.FW(FACTOR_W)) u_dp (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(load),
        .step_i(step),
        .fa_i  (fa),
        .fb_i  (fb),
        .acc_o (prod_o)
    );

    // R8
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(prod_o));

    // R9
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o));

endmodule

// File: tb/tb_clmul_unit.sv
module tb_clmul_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [127:0] opnd_a_i = '0;
    logic [127:0] opnd_b_i = '0;
    logic [7:0]   imm_i = '0;
    logic         busy_o, done_o;
    logic [127:0] prod_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    clmul_unit dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .opnd_a_i(opnd_a_i), .opnd_b_i(opnd_b_i), .imm_i(imm_i),
        .busy_o(busy_o), .done_o(done_o), .prod_o(prod_o)
    );

    function automatic logic [127:0] ref_mul(input logic [63:0] a, input logic [63:0] b);
        logic [127:0] r = '0;
        for (int i = 0; i < 64; i++)
            if (b[i]) r = r ^ ({64'd0, a} << i);
        return r;
    endfunction

    function automatic logic [127:0] ref_op(input logic [127:0] a, input logic [127:0] b,
                                            input logic [7:0] imm);
        logic [63:0] fa = imm[0] ? a[127:64] : a[63:0];
        logic [63:0] fb = imm[4] ? b[127:64] : b[63:0];
        return ref_mul(fa, fb);
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // runs one operation; intrude raises a start with other operands mid-run
    task automatic run_op(input logic [127:0] a, input logic [127:0] b,
                          input logic [7:0] imm, input string req, input bit intrude);
        logic [127:0] exp;
        logic [127:0] held;
        int k;
        exp = ref_op(a, b, imm);
        @(negedge clk);
        opnd_a_i = a; opnd_b_i = b; imm_i = imm; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        opnd_a_i = ~a; opnd_b_i = {b[63:0], b[127:64]} ^ 128'h5;
        k = 0;
        check({"R6 busy after start ", req}, {127'd0, busy_o}, 128'd1);
        while (!done_o && k < 200) begin
            @(negedge clk);
            k++;
            if (intrude && k == 10) begin
                start_i = 1'b1; imm_i = ~imm;
            end else if (intrude && k == 11) begin
                start_i = 1'b0;
            end
        end
        check({"R6 latency ", req}, 128'(k), 128'd64);
        check({"R6 busy low at done ", req}, {127'd0, busy_o}, 128'd0);
        check({"R1 product ", req}, prod_o, exp);
        check({"R10 top bit ", req}, {127'd0, prod_o[127]}, 128'd0);
        held = prod_o;
        @(negedge clk);
        check({"R7 done single ", req}, {127'd0, done_o}, 128'd0);
        opnd_a_i = $urandom(); imm_i = 8'hff;
        repeat (3) @(negedge clk);
        check({"R8 hold ", req}, prod_o, held);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] a, b;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        // R11
        check("R11 busy", {127'd0, busy_o}, 128'd0);
        check("R11 done", {127'd0, done_o}, 128'd0);
        check("R11 prod", prod_o, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        a = rnd128(); b = rnd128();
        run_op(a, b, 8'h00, "R2 low-low", 0);
        run_op(a, b, 8'h01, "R3 hiA-loB", 0);
        run_op(a, b, 8'h10, "R4 loA-hiB", 0);
        run_op(a, b, 8'h11, "R4 hiA-hiB", 0);
        run_op(a, b, 8'hEE, "R5 ignored bits as 00", 0);
        run_op(a, b, 8'hEF, "R5 ignored bits as 01", 0);
        run_op(a, b, 8'hFE, "R5 ignored bits as 10", 0);
        run_op(a, b, 8'hFF, "R5 ignored bits as 11", 0);
        run_op({64'd0, {64{1'b1}}}, {64'd0, {64{1'b1}}}, 8'h00, "R1 all ones", 0);
        run_op({64'h8000_0000_0000_0000, 64'd0}, {64'd0, 64'h8000_0000_0000_0000},
               8'h01, "R10 top bits", 0);
        run_op(128'd0, b, 8'h00, "R1 zero factor", 0);
        run_op({64'd1, 64'd1}, b, 8'h11, "R1 unit factor", 0);
        run_op(rnd128(), rnd128(), 8'h10, "R9 start while busy", 1);

        for (int i = 0; i < 24; i++) begin
            run_op(rnd128(), rnd128(), 8'($urandom()), "R1 random", (i % 6) == 5);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule